// File: doc/BRIEF.md
# Arithmetic-Logic Unit with Output Shifter and Status Flags

This block is the arithmetic core of a simple microcoded datapath. It combines two 32-bit operands. One comes from a dedicated holding register on the `a_in` side, and the other from whichever register the datapath has routed to `b_in`. The combination is chosen by a six-bit function control. A fixed shifter then passes the result through unchanged, moves it left by eight places, or moves it right by one place with sign extension. The shifted value leaves on `c_out` for the result bus.

The unshifted result also feeds two status bits, negative and zero. They are sampled into separate one-bit flip-flops on every rising clock edge, which is the same edge that writes the result registers. Sequencing logic reads them in the following cycle to choose a branch.

The whole path from operands to `c_out` is combinational. The only state in the block is the two flag flip-flops.

Top module: `alu_shift_unit`

## Requirements
- R1: With `fn_ctl[5:4]` = 00, the result before shifting is the bitwise AND of the prepared A operand and the prepared B operand.
- R2: With `fn_ctl[5:4]` = 01, the result before shifting is the bitwise OR of the prepared A operand and the prepared B operand.
- R3: With `fn_ctl[5:4]` = 10, the result before shifting is the bitwise complement of the prepared B operand. The A operand, `fn_ctl[1]` and `fn_ctl[0]` have no effect on it.
- R4: With `fn_ctl[5:4]` = 11, the result before shifting is the prepared A operand plus the prepared B operand plus `fn_ctl[0]` (carry-in), modulo 2^32. Setting `fn_ctl[1]` complements the A operand. Together these give A, B, NOT A, A+1, B+1, B−A, B−1, −A, 0, 1 and −1.
- R5: When `fn_ctl[3]` (A enable) is low, the A operand is forced to zero before the complement selected by `fn_ctl[1]` is applied. When `fn_ctl[2]` (B enable) is low, the B operand is forced to zero.
- R6: With `sh_ctl` = 10, `c_out` is the result shifted left by 8 bits, with zeros filling bits 7:0.
- R7: With `sh_ctl` = 01, `c_out` is the result shifted right by 1 bit, with bit 31 copied into bit 31 and bit 30.
- R8: With `sh_ctl` = 00 or 11, `c_out` equals the unshifted result.
- R9: `n_flag` takes bit 31 of the unshifted result at each rising clock edge while reset is low, regardless of the shift mode.
- R10: `z_flag` is set at each rising clock edge while reset is low exactly when the unshifted result is all zeros, regardless of the shift mode.
- R11: A synchronous active-high `rst` clears both `n_flag` and `z_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the flags are captured on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the flags |
| a_in | input | 32 | Operand from the holding register |
| b_in | input | 32 | Operand from the selected source register |
| fn_ctl | input | 6 | [5:4] function (00 AND, 01 OR, 10 NOT B, 11 add), [3] A enable, [2] B enable, [1] invert A, [0] carry-in |
| sh_ctl | input | 2 | [1] logical left shift by 8, [0] arithmetic right shift by 1; both or neither means no shift |
| c_out | output | 32 | Shifted result for the result bus |
| n_flag | output | 1 | Registered negative flag |
| z_flag | output | 1 | Registered zero flag |

## Verification
The bench sets up results whose sign or zeroness the shifter changes. One case turns 0x00800000 into a negative-looking `c_out` through the left shift. Another turns 1 into zero through the right shift. A design that took its flags after the shifter would report the wrong branch condition in both cases.

It runs all eleven adder forms with the A operand disabled and then inverted. A design that inverted A before forcing it to zero would give 0 where −1 is expected.

It also checks several other cases:
- NOT B with the invert and carry-in controls set. A design that let either control leak into that function would show a corrupted complement.
- Both shift controls asserted together. A design that gave one of the two modes priority would show a shifted value instead of the unshifted one.
- A negative value under the right shift, to catch a logical shift where an arithmetic one is required.

// File: rtl/alu_shift_pkg.sv
package alu_shift_pkg;

    localparam int unsigned DATA_W    = 32;
    localparam int unsigned LSH_AMT   = 8;
    localparam int unsigned CTL_W     = 6;
    localparam int unsigned SHCTL_W   = 2;

    // Function select field, bits [5:4] of the control word
    typedef enum logic [1:0] {
        FN_AND  = 2'b00,
        FN_OR   = 2'b01,
        FN_NOTB = 2'b10,
        FN_ADD  = 2'b11
    } alu_fn_e;

    // Six-bit control word: {fn, ena, enb, inva, inc}
    typedef struct packed {
        alu_fn_e fn;
        logic    ena;
        logic    enb;
        logic    inva;
        logic    inc;
    } alu_ctl_t;

    // Shifter mode after decode; the "both" code collapses to pass
    typedef enum logic [1:0] {
        SHM_PASS = 2'b00,
        SHM_SRA1 = 2'b01,
        SHM_SLL  = 2'b10
    } sh_mode_e;

    function automatic sh_mode_e decode_shift(input logic [SHCTL_W-1:0] sh);
        sh_mode_e m;
        case (sh)
            2'b10:   m = SHM_SLL;
            2'b01:   m = SHM_SRA1;
            default: m = SHM_PASS;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/alu_core.sv
module alu_core
    import alu_shift_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_ctl_t     ctl,
    output logic [W-1:0] res,
    output logic         neg,
    output logic         zero
);
    localparam int unsigned MSB = W - 1;

    logic [W-1:0] a_gated;
    logic [W-1:0] a_op;
    logic [W-1:0] b_op;
    logic [W-1:0] and_v;
    logic [W-1:0] or_v;
    logic [W-1:0] notb_v;
    logic [W-1:0] sum_v;

    // Operand preparation: gate to zero first, then optional inversion of A
    assign a_gated = ctl.ena ? a : '0;
    assign a_op    = a_gated ^ {W{ctl.inva}};
    assign b_op    = ctl.enb ? b : '0;

    // Bitwise logic slices
    for (genvar i = 0; i < W; i++) begin : g_slice
        assign and_v[i]  = a_op[i] & b_op[i];
        assign or_v[i]   = a_op[i] | b_op[i];
        assign notb_v[i] = ~b_op[i];
    end

    assign sum_v = a_op + b_op + W'(ctl.inc);

    always_comb begin
        case (ctl.fn)
            FN_AND:  res = and_v;
            FN_OR:   res = or_v;
            FN_NOTB: res = notb_v;
            default: res = sum_v;
        endcase
    end

    assign neg  = res[MSB];
    assign zero = (res == '0);

    // Structural properties of each function
    always_comb begin
        if (ctl.fn == FN_AND)
            a_r1_and_within_b: assert ((res & ~b_op) == '0);
        if (ctl.fn == FN_OR)
            a_r2_or_covers_b: assert ((res & b_op) == b_op);
        if (ctl.fn == FN_NOTB)
            a_r3_notb_disjoint: assert ((res & b_op) == '0);
        if (ctl.fn == FN_ADD && !ctl.ena && !ctl.enb && !ctl.inva)
            a_r5_gated_constant: assert (res == W'(ctl.inc));
    end

endmodule

// File: rtl/alu_shifter.sv
module alu_shifter
    import alu_shift_pkg::*;
#(
    parameter int unsigned W   = DATA_W,
    parameter int unsigned LSH = LSH_AMT
) (
    input  logic [W-1:0]       din,
    input  logic [SHCTL_W-1:0] sh,
    output logic [W-1:0]       dout
);
    localparam int unsigned MSB = W - 1;

    sh_mode_e     mode;
    logic [W-1:0] sll_v;
    logic [W-1:0] sra_v;

    assign mode = decode_shift(sh);

    if (LSH < W) begin : g_sll
        assign sll_v = {din[W-LSH-1:0], {LSH{1'b0}}};
    end else begin : g_sll_all
        assign sll_v = '0;
    end

    assign sra_v = {din[MSB], din[MSB:1]};

    always_comb begin
        case (mode)
            SHM_SLL:  dout = sll_v;
            SHM_SRA1: dout = sra_v;
            default:  dout = din;
        endcase
    end

    always_comb begin
        if (mode == SHM_SLL)
            a_r6_low_zero: assert (dout[LSH-1:0] == '0);
        if (mode == SHM_SRA1)
            a_r7_sign_kept: assert (dout[MSB] == din[MSB] && dout[MSB-1] == din[MSB]);
        if (sh == 2'b11)
            a_r8_both_pass: assert (dout == din);
    end

endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg (
    input  logic clk,
    input  logic rst,
    input  logic neg_d,
    input  logic zero_d,
    output logic n_q,
    output logic z_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            n_q <= 1'b0;
            z_q <= 1'b0;
        end else begin
            n_q <= neg_d;
            z_q <= zero_d;
        end
    end

    // A zero value is never negative
    a_r10_zero_not_neg: assert property (@(posedge clk) disable iff (rst)
        z_q |-> !n_q);

endmodule

// File: rtl/alu_shift_unit.sv
module alu_shift_unit
    import alu_shift_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [W-1:0]       a_in,
    input  logic [W-1:0]       b_in,
    input  logic [CTL_W-1:0]   fn_ctl,
    input  logic [SHCTL_W-1:0] sh_ctl,
    output logic [W-1:0]       c_out,
    output logic               n_flag,
    output logic               z_flag
);
    localparam int unsigned MSB = W - 1;

    alu_ctl_t     ctl;
    logic [W-1:0] alu_res;
    logic         alu_neg;
    logic         alu_zero;

    assign ctl = alu_ctl_t'(fn_ctl);

    alu_core #(.W(W)) u_core (
        .a    (a_in),
        .b    (b_in),
        .ctl  (ctl),
        .res  (alu_res),
        .neg  (alu_neg),
        .zero (alu_zero)
    );

    alu_shifter #(.W(W), .LSH(LSH_AMT)) u_shift (
        .din  (alu_res),
        .sh   (sh_ctl),
        .dout (c_out)
    );

    alu_flag_reg u_flags (
        .clk    (clk),
        .rst    (rst),
        .neg_d  (alu_neg),
        .zero_d (alu_zero),
        .n_q    (n_flag),
        .z_q    (z_flag)
    );

    // Flags follow the pre-shift result one edge later
    a_r9_n_tracks: assert property (@(posedge clk) disable iff (rst)
        !rst |=> n_flag == $past(alu_res[MSB]));
    a_r10_z_tracks: assert property (@(posedge clk) disable iff (rst)
        !rst |=> z_flag == ($past(alu_res) == '0));

endmodule

// File: tb/alu_shift_unit_tb.sv
module alu_shift_unit_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] a_in = '0;
    logic [31:0] b_in = '0;
    logic [5:0]  fn_ctl = '0;
    logic [1:0]  sh_ctl = '0;
    logic [31:0] c_out;
    logic        n_flag;
    logic        z_flag;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    alu_shift_unit u_dut (
        .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
        .fn_ctl(fn_ctl), .sh_ctl(sh_ctl),
        .c_out(c_out), .n_flag(n_flag), .z_flag(z_flag)
    );

    function automatic logic [5:0] cw(input logic [1:0] f, input logic ea,
                                      input logic eb, input logic ia, input logic ci);
        return {f, ea, eb, ia, ci};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // Drive at the falling edge, then sample the combinational output
    task automatic drive(input logic [31:0] a, input logic [31:0] b,
                         input logic [5:0] f, input logic [1:0] s);
        @(negedge clk);
        a_in = a; b_in = b; fn_ctl = f; sh_ctl = s;
        #1;
    endtask

    // Wait past the capturing edge, then sample the flags
    task automatic flags_after(input string req, input logic en, input logic ez);
        @(posedge clk);
        #1;
        check(req, {31'b0, n_flag}, {31'b0, en});
        check(req, {31'b0, z_flag}, {31'b0, ez});
    endtask

    task automatic t_reset();
        drive(32'hFFFF_FFFF, 32'h0, cw(2'b11, 1, 0, 0, 0), 2'b00);
        @(posedge clk); #1;
        check("R11 n", {31'b0, n_flag}, 32'h0);
        check("R11 z", {31'b0, z_flag}, 32'h0);
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic t_logic();
        logic [31:0] a = 32'hF0F0_1234;
        logic [31:0] b = 32'h0FF0_FF00;
        drive(a, b, cw(2'b00, 1, 1, 0, 0), 2'b00); check("R1 and", c_out, a & b);
        drive(a, b, cw(2'b00, 1, 1, 1, 0), 2'b00); check("R1 and inv", c_out, ~a & b);
        drive(a, b, cw(2'b01, 1, 1, 0, 0), 2'b00); check("R2 or", c_out, a | b);
        drive(a, b, cw(2'b01, 0, 1, 0, 0), 2'b00); check("R2 or gated", c_out, b);
        drive(a, b, cw(2'b10, 1, 1, 0, 0), 2'b00); check("R3 notb", c_out, ~b);
        drive(a, b, cw(2'b10, 1, 1, 1, 1), 2'b00); check("R3 notb ctl ignored", c_out, ~b);
        drive(a, b, cw(2'b10, 1, 0, 0, 0), 2'b00); check("R3 notb gated", c_out, 32'hFFFF_FFFF);
    endtask

    task automatic t_add_forms();
        logic [31:0] a = 32'h1234_5678;
        logic [31:0] b = 32'h0000_1000;
        drive(a, b, cw(2'b11, 1, 1, 0, 0), 2'b00); check("R4 a+b", c_out, a + b);
        drive(a, b, cw(2'b11, 1, 0, 0, 0), 2'b00); check("R4 A", c_out, a);
        drive(a, b, cw(2'b11, 0, 1, 0, 0), 2'b00); check("R4 B", c_out, b);
        drive(a, b, cw(2'b11, 1, 0, 1, 0), 2'b00); check("R4 notA", c_out, ~a);
        drive(a, b, cw(2'b11, 1, 0, 0, 1), 2'b00); check("R4 A+1", c_out, a + 1);
        drive(a, b, cw(2'b11, 0, 1, 0, 1), 2'b00); check("R4 B+1", c_out, b + 1);
        drive(a, b, cw(2'b11, 1, 1, 1, 1), 2'b00); check("R4 B-A", c_out, b - a);
        drive(a, b, cw(2'b11, 0, 1, 1, 0), 2'b00); check("R4 B-1", c_out, b - 1);
        drive(a, b, cw(2'b11, 1, 0, 1, 1), 2'b00); check("R4 -A", c_out, -a);
        drive(a, b, cw(2'b11, 0, 0, 0, 0), 2'b00); check("R5 zero", c_out, 32'h0);
        drive(a, b, cw(2'b11, 0, 0, 0, 1), 2'b00); check("R5 one", c_out, 32'h1);
        drive(a, b, cw(2'b11, 0, 0, 1, 0), 2'b00); check("R5 minus one", c_out, 32'hFFFF_FFFF);
        drive(32'hFFFF_FFFF, 32'h1, cw(2'b11, 1, 1, 0, 0), 2'b00); check("R4 wrap", c_out, 32'h0);
    endtask

    task automatic t_shift();
        drive(32'h8123_4567, 0, cw(2'b11, 1, 0, 0, 0), 2'b10); check("R6 sll8", c_out, 32'h2345_6700);
        drive(32'h8123_4567, 0, cw(2'b11, 1, 0, 0, 0), 2'b01); check("R7 sra neg", c_out, 32'hC091_A2B3);
        drive(32'h4000_0002, 0, cw(2'b11, 1, 0, 0, 0), 2'b01); check("R7 sra pos", c_out, 32'h2000_0001);
        drive(32'h8123_4567, 0, cw(2'b11, 1, 0, 0, 0), 2'b11); check("R8 both", c_out, 32'h8123_4567);
        drive(32'h8123_4567, 0, cw(2'b11, 1, 0, 0, 0), 2'b00); check("R8 none", c_out, 32'h8123_4567);
    endtask

    task automatic t_flags();
        drive(32'h0080_0000, 0, cw(2'b11, 1, 0, 0, 0), 2'b10);
        check("R9 shifted out", c_out, 32'h8000_0000);
        flags_after("R9 pre-shift sign", 1'b0, 1'b0);
        drive(32'h0000_0001, 0, cw(2'b11, 1, 0, 0, 0), 2'b01);
        check("R10 shifted out", c_out, 32'h0);
        flags_after("R10 pre-shift nonzero", 1'b0, 1'b0);
        drive(32'h8000_0000, 0, cw(2'b11, 1, 0, 0, 0), 2'b10);
        flags_after("R9 negative", 1'b1, 1'b0);
        drive(32'h5, 32'h5, cw(2'b11, 1, 1, 1, 1), 2'b00);
        flags_after("R10 zero", 1'b0, 1'b1);
        drive(32'h0, 32'h0, cw(2'b11, 0, 0, 1, 0), 2'b01);
        flags_after("R9 minus one", 1'b1, 1'b0);
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_logic();
        t_add_forms();
        t_shift();
        t_flags();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule